// File: doc/BRIEF.md
# Pulse Width and Period Capture Channel

This block is one input-capture channel with its own free-running time base. It stamps every edge of one external signal with the current counter value. In hardware, it then decides whether the edge closes an active phase (a pulse width) or opens the next active phase (a period). It works out both intervals by subtracting the counter values. Software reads the most recent width, period and raw timestamp through a small word-addressed register port. It also sees three sticky status bits, which it clears by writing ones.

The counter runs from the core clock through a prescaler that divides by 1 to 4. A polarity bit says which input level counts as the active phase. A channel-off bit parks the channel; it is set at reset. A flag-enable bit routes the capture flag to an interrupt line. The counter width is a parameter (24 bits by default), and all interval arithmetic wraps modulo two to that width.

Register map (word address on `bus_addr`): 0 control, 1 status, 2 width, 3 period, 4 timestamp. Control bits: [0] channel off, [1] polarity (1 = active high), [2] flag enable, [3] prescaler enable, [5:4] divide ratio minus one. Status bits: [0] capture flag, [1] counter overflow, [2] overrun. Reads return data one clock after the read strobe. Writes take effect at the clock edge that samples the write strobe.

Top module: `pwcap_channel`

## Requirements
- R1: After reset, control reads 0x01 (channel off, all other fields 0). Status, width, period and timestamp read 0, and `irq` is low.
- R2: While the channel runs (control bit 0 = 0) and the prescaler is enabled (control bit 3 = 1), the counter advances by exactly one every (control[5:4] + 1) clocks. Intervals therefore read as the elapsed clocks divided by 1, 2, 3 or 4.
- R3: While the channel runs, each rising and each falling edge of the synchronized input stores the counter value in the timestamp register (address 4) and sets status bit 0.
- R4: With polarity = 1, a rising edge ends a period and a falling edge ends a width. Width (address 2) = falling-edge stamp minus the latest rising-edge stamp. Period (address 3) = rising-edge stamp minus the previous rising-edge stamp.
- R5: With polarity = 0, the roles swap: falling edges end periods and rising edges end widths, using the same arithmetic.
- R6: Whenever the channel is off, the reference stamp is zero. The first period edge after the channel is switched on therefore yields a period equal to its own timestamp.
- R7: Width and period wrap modulo 2^CNT_W, so an interval that spans a counter wrap still reads as the true elapsed count.
- R8: Status bit 1 sets when the counter steps from all ones to zero.
- R9: Status bit 2 sets when a capture occurs while status bit 0 is already set.
- R10: Writing the status register clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R11: With the channel off (control bit 0 = 1), input edges change neither timestamp, width, period nor status bit 0.
- R12: `irq` equals status bit 0 gated by control bit 2. Clearing control bit 2 masks `irq`, but captures still take place.
- R13: With the prescaler disabled (control bit 3 = 0), the counter holds its value. Edges captured in that state all carry the same stamp and give zero-length intervals.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one clock after `bus_re` |
| cap_in | input | 1 | Asynchronous signal being measured |
| irq | output | 1 | Capture interrupt request |

## Verification
The embedded properties check the local invariants on every clock:
- the counter only ever steps by one and freezes when its enable is absent;
- a wrap returns it to zero;
- a period capture reloads the reference and produces stamp-minus-old-reference;
- a width capture leaves the period untouched;
- a parked channel keeps its timestamp;
- overrun and un-cleared overflow are sticky.

Only the bench scenarios can show the end-to-end numbers. These are the measured widths and periods for both polarities and all four divide ratios, the wrap-spanning intervals, and the zero reference after enabling. They also include write-one-to-clear semantics on mixed status patterns and the interrupt masking that leaves capture running.

// File: rtl/pwcap_pkg.sv
package pwcap_pkg;

    localparam int PRE_W  = 2;
    localparam int ADDR_W = 3;
    localparam int DATA_W = 32;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL   = 3'd0,
        REG_STAT   = 3'd1,
        REG_WIDTH  = 3'd2,
        REG_PERIOD = 3'd3,
        REG_STAMP  = 3'd4
    } reg_addr_e;

    // control word, LSB first: off, polarity, flag enable, prescaler enable, ratio-1
    typedef struct packed {
        logic [PRE_W-1:0] ratio_m1;
        logic             pre_en;
        logic             flag_en;
        logic             pol_high;
        logic             chan_off;
    } ctrl_t;

    typedef struct packed {
        logic overrun;
        logic overflow;
        logic cap_flag;
    } stat_t;

    localparam int CTRL_BITS = $bits(ctrl_t);
    localparam int STAT_BITS = $bits(stat_t);

    localparam ctrl_t CTRL_RESET = '{ratio_m1: '0, pre_en: 1'b0, flag_en: 1'b0,
                                     pol_high: 1'b0, chan_off: 1'b1};

    // an edge that leaves the input at the active level closes a period
    function automatic logic ends_period(logic level, logic pol_high);
        return level == pol_high;
    endfunction

endpackage

// File: rtl/pwcap_sync.sv
module pwcap_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic level,
    output logic toggled
);
    // STAGES synchronizer flops plus one history flop for edge detection
    logic [STAGES:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= {sh_q[STAGES-1:0], din};
    end

    assign level   = sh_q[STAGES-1];
    assign toggled = sh_q[STAGES] ^ sh_q[STAGES-1];

endmodule

// File: rtl/pwcap_timebase.sv
module pwcap_timebase
    import pwcap_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             pre_en,
    input  logic [PRE_W-1:0] ratio_m1,
    output logic [CNT_W-1:0] count,
    output logic             wrap
);
    logic [PRE_W-1:0] psc_q;
    logic             active;
    logic             tick;

    assign active = run && pre_en;
    assign tick   = active && (psc_q >= ratio_m1);
    assign wrap   = tick && (count == {CNT_W{1'b1}});

    always_ff @(posedge clk) begin
        if (rst)          psc_q <= '0;
        else if (!active) psc_q <= '0;
        else if (tick)    psc_q <= '0;
        else              psc_q <= psc_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)       count <= '0;
        else if (tick) count <= count + 1'b1;
    end

    // R13: counter frozen without both enables
    p_freeze_r13: assert property (@(posedge clk) disable iff (rst)
        !(run && pre_en) |=> $stable(count));

    // R2: the counter only ever advances by one
    p_step_one_r2: assert property (@(posedge clk) disable iff (rst)
        !$stable(count) |-> count == $past(count) + 1'b1);

    // R8: a wrap lands on zero
    p_wrap_zero_r8: assert property (@(posedge clk) disable iff (rst)
        wrap |=> count == '0);

endmodule

// File: rtl/pwcap_calc.sv
module pwcap_calc
    import pwcap_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             cap_valid,
    input  logic             level,
    input  logic             pol_high,
    input  logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] width_q,
    output logic [CNT_W-1:0] period_q,
    output logic [CNT_W-1:0] stamp_q
);
    logic [CNT_W-1:0] ref_q;
    logic             per_edge;
    logic [CNT_W-1:0] delta;

    assign per_edge = ends_period(level, pol_high);
    assign delta    = count - ref_q;

    always_ff @(posedge clk) begin
        if (rst)                        ref_q <= '0;
        else if (!run)                  ref_q <= '0;
        else if (cap_valid && per_edge) ref_q <= count;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            width_q  <= '0;
            period_q <= '0;
            stamp_q  <= '0;
        end else if (cap_valid) begin
            stamp_q <= count;
            if (per_edge) period_q <= delta;
            else          width_q  <= delta;
        end
    end

    // R4: a period capture measures from the old reference to its own stamp
    p_period_calc_r4: assert property (@(posedge clk) disable iff (rst)
        (cap_valid && per_edge) |=> period_q == stamp_q - $past(ref_q));

    // R5: a width capture never disturbs the period
    p_width_only_r5: assert property (@(posedge clk) disable iff (rst)
        (cap_valid && !per_edge) |=> $stable(period_q));

    // R6: a parked channel holds a zero reference
    p_ref_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (!run && !$past(cap_valid)) |=> ref_q == '0);

endmodule

// File: rtl/pwcap_channel.sv
module pwcap_channel
    import pwcap_pkg::*;
#(
    parameter int CNT_W       = 24,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              cap_in,
    output logic              irq
);
    ctrl_t            ctrl_q;
    stat_t            stat_q;
    logic             run;
    logic             level;
    logic             toggled;
    logic             cap_valid;
    logic [CNT_W-1:0] count;
    logic             wrap;
    logic [CNT_W-1:0] width_q;
    logic [CNT_W-1:0] period_q;
    logic [CNT_W-1:0] stamp_q;
    logic [STAT_BITS-1:0] clr;
    logic             unused_wdata;

    assign unused_wdata = ^bus_wdata[DATA_W-1:CTRL_BITS];

    assign run       = !ctrl_q.chan_off;
    assign cap_valid = toggled && run;
    assign irq       = stat_q.cap_flag && ctrl_q.flag_en;

    pwcap_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .din(cap_in), .level(level), .toggled(toggled)
    );

    pwcap_timebase #(.CNT_W(CNT_W)) u_tb (
        .clk(clk), .rst(rst), .run(run), .pre_en(ctrl_q.pre_en),
        .ratio_m1(ctrl_q.ratio_m1), .count(count), .wrap(wrap)
    );

    pwcap_calc #(.CNT_W(CNT_W)) u_calc (
        .clk(clk), .rst(rst), .run(run), .cap_valid(cap_valid), .level(level),
        .pol_high(ctrl_q.pol_high), .count(count), .width_q(width_q),
        .period_q(period_q), .stamp_q(stamp_q)
    );

    always_ff @(posedge clk) begin
        if (rst)                                   ctrl_q <= CTRL_RESET;
        else if (bus_we && bus_addr == REG_CTRL)   ctrl_q <= ctrl_t'(bus_wdata[CTRL_BITS-1:0]);
    end

    assign clr = (bus_we && bus_addr == REG_STAT) ? bus_wdata[STAT_BITS-1:0] : '0;

    // setting wins over a same-cycle clear
    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
        end else begin
            stat_q.cap_flag <= (stat_q.cap_flag & ~clr[0]) | cap_valid;
            stat_q.overflow <= (stat_q.overflow & ~clr[1]) | wrap;
            stat_q.overrun  <= (stat_q.overrun  & ~clr[2]) | (cap_valid & stat_q.cap_flag);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else if (bus_re) begin
            case (bus_addr)
                REG_CTRL:   bus_rdata <= DATA_W'(ctrl_q);
                REG_STAT:   bus_rdata <= DATA_W'(stat_q);
                REG_WIDTH:  bus_rdata <= DATA_W'(width_q);
                REG_PERIOD: bus_rdata <= DATA_W'(period_q);
                REG_STAMP:  bus_rdata <= DATA_W'(stamp_q);
                default:    bus_rdata <= '0;
            endcase
        end
    end

    // R11: a parked channel keeps its timestamp
    p_off_hold_r11: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.chan_off |=> $stable(stamp_q));

    // R9: capture on a pending flag raises overrun
    p_overrun_r9: assert property (@(posedge clk) disable iff (rst)
        (cap_valid && stat_q.cap_flag) |=> stat_q.overrun);

    // R10: a zero written to the overflow bit keeps it
    p_keep_ovf_r10: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == REG_STAT && !bus_wdata[1] && stat_q.overflow) |=> stat_q.overflow);

    // R3: every captured edge leaves the flag set
    p_flag_set_r3: assert property (@(posedge clk) disable iff (rst)
        cap_valid |=> stat_q.cap_flag);

endmodule

// File: tb/pwcap_channel_test.sv
`timescale 1ns/1ps
module pwcap_channel_test;

    localparam int CW   = 12;
    localparam int MASK = (1 << CW) - 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        sig = 1'b0;
    logic        irq;

    always #10 clk = ~clk;

    pwcap_channel #(.CNT_W(CW)) uut (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cap_in(sig), .irq(irq)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    int cyc    = 0;

    always @(posedge clk) cyc <= cyc + 1;

    typedef struct { int w; int p; string tag; } exp_t;
    exp_t sb_q[$];
    event item_ev;

    logic act_lvl = 1'b1;
    int   ratio   = 1;
    bit   ref_ok  = 0;
    int   last_act = 0;
    int   last_inact = 0;
    string cur_tag = "R4";

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // bus tasks are entered on a falling edge and return on one
    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        bus_re = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_re = 1'b0;
        v = bus_rdata;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    function automatic logic [31:0] cw(bit off, bit pol, bit fen, bit pen, int rat);
        logic [1:0] r = rat[1:0];
        return {26'd0, r, pen, fen, pol, off};
    endfunction

    // driver: moves the input and pushes the expected width/period
    task automatic set_sig(input logic v);
        exp_t e;
        sig = v;
        if (v == act_lvl) begin
            if (ref_ok) begin
                e.w = ((last_inact - last_act) / ratio) & MASK;
                e.p = ((cyc - last_act) / ratio) & MASK;
                e.tag = cur_tag;
                sb_q.push_back(e);
                -> item_ev;
            end
            last_act = cyc;
            ref_ok = 1;
        end else begin
            last_inact = cyc;
        end
    endtask

    task automatic train(input int h, input int l, input int n);
        for (int i = 0; i < n; i++) begin
            set_sig(act_lvl);
            repeat (h) @(negedge clk);
            set_sig(!act_lvl);
            repeat (l) @(negedge clk);
        end
    endtask

    // park, reprogram with prescaler off, then run
    task automatic setup(input bit pol, input int rat, input bit pen);
        wr(0, cw(1, pol, 0, 0, rat - 1));
        act_lvl = pol;
        sig = !pol;
        ratio = rat;
        repeat (6) @(negedge clk);
        wr(0, cw(0, pol, 0, pen, rat - 1));
        ref_ok = 0;
        repeat (4) @(negedge clk);
    endtask

    // monitor: compares the design's results as each period completes
    initial begin
        exp_t e;
        logic [31:0] v;
        forever begin
            @(item_ev);
            repeat (5) @(negedge clk);
            e = sb_q.pop_front();
            rd(3'd2, v);
            check({e.tag, " width"}, v, e.w);
            rd(3'd3, v);
            check({e.tag, " period"}, v, e.p);
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, c1, c2, w0, p0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(3'd0, v); check("R1 ctrl", v, 32'h1);
        rd(3'd1, v); check("R1 status", v, 0);
        rd(3'd2, v); check("R1 width", v, 0);
        rd(3'd3, v); check("R1 period", v, 0);
        rd(3'd4, v); check("R1 stamp", v, 0);
        check("R1 irq", {31'd0, irq}, 0);

        // R6 first period after enabling, R3 flag, then R4 trains
        setup(1, 1, 1);
        set_sig(1'b1);
        repeat (6) @(negedge clk);
        rd(3'd4, c1);
        rd(3'd3, v);
        check("R6 first period equals stamp", v, c1);
        rd(3'd1, v);
        check("R3 capture flag", v & 32'h1, 1);
        repeat (10) @(negedge clk);
        set_sig(1'b0);
        repeat (20) @(negedge clk);
        cur_tag = "R4";
        train(13, 31, 3);
        train(40, 17, 3);
        repeat (20) @(negedge clk);

        // R5 active-low, divide by 2
        setup(0, 2, 1);
        cur_tag = "R5";
        train(24, 36, 4);
        repeat (20) @(negedge clk);

        // R2 divide by 3 and by 4
        setup(1, 3, 1);
        cur_tag = "R2";
        train(24, 48, 3);
        train(36, 12, 3);
        repeat (20) @(negedge clk);
        setup(0, 4, 1);
        train(36, 20, 3);
        repeat (20) @(negedge clk);

        // R13 frozen counter
        setup(1, 1, 0);
        sig = 1'b1; repeat (20) @(negedge clk);
        sig = 1'b0; repeat (20) @(negedge clk);
        sig = 1'b1; repeat (8) @(negedge clk);
        rd(3'd2, v); check("R13 width frozen", v, 0);
        rd(3'd3, v); check("R13 period frozen", v, 0);

        // R7 intervals spanning wraps, R8 overflow
        setup(1, 1, 1);
        wr(3'd1, 32'h7);
        cur_tag = "R7";
        train(1500, 1600, 4);
        repeat (20) @(negedge clk);
        rd(3'd1, v); check("R8 overflow bit", (v >> 1) & 1, 1);

        // R9 overrun, R10 write-one-to-clear
        wr(3'd1, 32'h7);
        rd(3'd1, v); check("R10 cleared", v & 32'h5, 0);
        sig = 1'b1; repeat (6) @(negedge clk);
        rd(3'd1, v); check("R9 one capture", v & 32'h5, 1);
        sig = 1'b0; repeat (6) @(negedge clk);
        rd(3'd1, v); check("R9 overrun set", v & 32'h5, 5);
        wr(3'd1, 32'h0);
        rd(3'd1, v); check("R10 zero write", v & 32'h5, 5);
        wr(3'd1, 32'h1);
        rd(3'd1, v); check("R10 clear flag only", v & 32'h5, 4);
        wr(3'd1, 32'h4);
        rd(3'd1, v); check("R10 clear overrun", v & 32'h5, 0);

        // R12 interrupt gating
        wr(3'd0, cw(0, 1, 1, 1, 0));
        sig = 1'b1; repeat (6) @(negedge clk);
        check("R12 irq raised", {31'd0, irq}, 1);
        wr(3'd0, cw(0, 1, 0, 1, 0));
        check("R12 irq masked", {31'd0, irq}, 0);
        rd(3'd1, v); check("R12 flag kept", v & 32'h1, 1);
        rd(3'd4, c1);
        sig = 1'b0; repeat (6) @(negedge clk);
        rd(3'd4, c2);
        check("R12 capture continues", {31'd0, c2 != c1}, 1);
        wr(3'd0, cw(0, 1, 1, 1, 0));
        check("R12 irq unmasked", {31'd0, irq}, 1);
        wr(3'd1, 32'h1);
        check("R12 irq after clear", {31'd0, irq}, 0);

        // R11 parked channel ignores edges
        wr(3'd0, cw(1, 1, 0, 1, 0));
        wr(3'd1, 32'h7);
        rd(3'd4, c1); rd(3'd2, w0); rd(3'd3, p0);
        for (int i = 0; i < 4; i++) begin
            sig = ~sig;
            repeat (10) @(negedge clk);
        end
        rd(3'd1, v); check("R11 no flag", v & 32'h1, 0);
        rd(3'd4, v); check("R11 stamp held", v, c1);
        rd(3'd2, v); check("R11 width held", v, w0);
        rd(3'd3, v); check("R11 period held", v, p0);

        if (!done) begin
            done = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule